// File: doc/BRIEF.md
# ADC serial command and data port

This block is the slave side of the serial port of a converter that produces a 12-bit-plus-sign two's-complement result. A host frames each exchange with an active-low select and a serial clock. On every rising clock edge the port takes one command bit from the host. On every falling edge it presents the next bit of the last stored result, most significant bit first. The first result bit is not launched by a clock edge. It appears when select falls, or, if select is held low without a break, when the conversion sequencer reports that it has finished.

Every pin from the host passes through a two-flop synchronizer into one system clock domain, and the port finds the edges there. At the end of each complete frame the command sets two things: the multiplexer address and the output word length, which is either 13 bits or 9 bits. The port then asks the sequencer to start a conversion. A read-only input freezes the configuration, so that frames only unload the stored result. If select falls while a conversion is running, the port aborts that conversion and marks the stored result as stale.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the data-out enable is low, the ready flag is high, the start and abort pulses are low, the multiplexer address is 0 and the word length is 13 bits (short-word flag low).
- R2: The data-out enable is high while select is low and low while select is high; data-out reads 0 while the enable is low.
- R3: A falling edge of select launches bit 12 (the sign) of the stored result on data-out. Each later falling serial clock edge presents the next lower bit, so a 13-bit frame returns the full two's-complement result MSB first.
- R4: The ready flag goes low when the first bit is launched, stays low until the falling serial clock edge that matches the programmed word length, and then goes high.
- R5: The first bits received in a frame form the command, MSB first: the first three set the multiplexer address (first bit = address bit 2), and the fourth selects the word length (1 = 9 bits, 0 = 13 bits). Later bits are ignored.
- R6: A one-cycle start pulse is issued, and the command is applied, on the falling serial clock edge that completes a frame, provided that read-only is low and the number of rising edges in the frame equals the programmed word length.
- R7: A frame that select ends before its word length is reached issues no start pulse and leaves the address and word length unchanged.
- R8: While read-only is high, data-in is ignored, no start pulse is issued, and the address and word length keep their values, but the stored result is still shifted out.
- R9: In 9-bit mode a frame takes 9 serial clocks and returns result bits 12 down to 4. The ready flag rises on the 9th falling edge.
- R10: With select held low continuously, an end-of-conversion pulse launches bit 12 of the new result and drives the ready flag low.
- R11: A falling edge of select while a conversion is outstanding (started and not yet ended) gives a one-cycle abort pulse and raises the stale flag. The next end-of-conversion pulse clears the stale flag.
- R12: The result input is captured on every end-of-conversion pulse and becomes the word that later frames return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host select, active low |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Host serial data into the port |
| rdonly_i | input | 1 | High: read-only frames, configuration frozen |
| res_i | input | 13 | Conversion result from the sequencer, two's complement |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse from the sequencer |
| sdo_o | output | 1 | Serial result data toward the host |
| sdo_oe_o | output | 1 | Drive enable for the tri-state data-out pad |
| rdy_o | output | 1 | Data-output-ready flag, low while bits are still pending |
| mux_addr_o | output | 3 | Multiplexer address taken from the last applied command |
| short_word_o | output | 1 | High when 9-bit words are programmed |
| conv_start_o | output | 1 | One-cycle start request to the sequencer |
| conv_abort_o | output | 1 | One-cycle abort request to the sequencer |
| res_stale_o | output | 1 | Stored result belongs to an aborted conversion |

## Verification
Two situations are hard to reach from the ports. The first is the continuous-select case, where the first bit comes from the sequencer and no select edge exists. The bench reaches it by finishing a configuration frame, keeping select low, and then pulsing end-of-conversion, after which it checks the sign bit and the ready flag before any clock edge arrives. The second is the abort. It needs a conversion still outstanding when select falls again, so the bench issues a start frame, withholds end-of-conversion, and reopens select. The bench also runs a sweep of result values through read-only frames, which confirms bit order and sign handling and shows that a command word of all ones changes nothing.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  localparam int RES_W   = 13;
  localparam int SHORT_W = 9;
  localparam int ADDR_W  = 3;
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int          N       = 1,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adc_sp_rx.sv
module adc_sp_rx #(
  parameter int RES_W   = 13,
  parameter int SHORT_W = 9,
  parameter int ADDR_W  = 3,
  localparam int CMD_W  = ADDR_W + 1,
  localparam int CNT_W  = $clog2(RES_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              launch_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic              lock_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              short_o,
  output logic              start_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              short_q, short_d;
  logic              start_q, start_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  exp_len;

  assign exp_len = short_q ? CNT_W'(SHORT_W) : CNT_W'(RES_W);

  always_comb begin
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    short_d = short_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    if (launch_i || !active_i) begin
      cnt_d = '0;
    end else if (sclk_rise_i && (cnt_q < CNT_W'(RES_W))) begin
      cnt_d = cnt_q + 1'b1;
      if (!lock_i) begin
        for (int i = 0; i < CMD_W; i++) begin
          if (cnt_q == CNT_W'(i)) cmd_d[CMD_W-1-i] = sdi_i;
        end
      end
    end
    if (active_i && !launch_i && sclk_fall_i && (cnt_q == exp_len)) begin
      done_d = 1'b1;
      if (!lock_i) begin
        addr_d  = cmd_q[CMD_W-1 -: ADDR_W];
        short_d = cmd_q[0];
        start_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      short_q <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      short_q <= short_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign done_o  = done_q;
  assign addr_o  = addr_q;
  assign short_o = short_q;
  assign start_o = start_q;

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_start_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(!lock_i));
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(addr_q) || !$stable(short_q)) |-> start_q);
endmodule

// File: rtl/adc_sp_tx.sv
module adc_sp_tx #(
  parameter int RES_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_low_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             done_i,
  input  logic             eoc_i,
  input  logic [RES_W-1:0] res_i,
  output logic             launch_o,
  output logic             active_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             rdy_o
);
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] sr_q, sr_d;
  logic             active_q, active_d;
  logic             launch;

  assign launch = cs_fall_i || (eoc_i && cs_low_i);

  always_comb begin
    res_d    = eoc_i ? res_i : res_q;
    sr_d     = sr_q;
    active_d = active_q;
    if (launch) begin
      sr_d     = eoc_i ? res_i : res_q;
      active_d = 1'b1;
    end else begin
      if (sclk_fall_i && active_q) sr_d = {sr_q[RES_W-2:0], 1'b0};
      if (done_i || cs_rise_i)     active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '0;
      sr_q     <= '0;
      active_q <= 1'b0;
    end else begin
      res_q    <= res_d;
      sr_q     <= sr_d;
      active_q <= active_d;
    end
  end

  assign launch_o = launch;
  assign active_o = active_q;
  assign rdy_o    = !active_q;
  assign sdo_oe_o = cs_low_i;
  assign sdo_o    = cs_low_i ? sr_q[RES_W-1] : 1'b0;

  p_rdy_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low_i && $past(!cs_low_i)) |-> rdy_o);
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !launch) |=> $stable(sr_q));
  p_quiet_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W   = adc_sp_pkg::RES_W,
  parameter int SHORT_W = adc_sp_pkg::SHORT_W,
  parameter int ADDR_W  = adc_sp_pkg::ADDR_W,
  parameter int SYNC_N  = adc_sp_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              rdonly_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              eoc_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rdy_o,
  output logic [ADDR_W-1:0] mux_addr_o,
  output logic              short_word_o,
  output logic              conv_start_o,
  output logic              conv_abort_o,
  output logic              res_stale_o
);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0] pins_s;
  logic             cs_s, sclk_s, sdi_s, lock_s;
  logic             cs_prev_q, sclk_prev_q;
  logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic             launch, active, done;
  logic             busy_q, busy_d, abort_q, abort_d, stale_q, stale_d;

  adc_sp_sync #(.N(PIN_N), .STAGES(SYNC_N), .RST_VAL(4'b1000)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cs_n_i, sclk_i, sdi_i, rdonly_i}),
    .q_o  (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s, lock_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_prev_q && !cs_s;
  assign cs_rise   = !cs_prev_q && cs_s;
  assign sclk_rise = !sclk_prev_q && sclk_s && !cs_s;
  assign sclk_fall = sclk_prev_q && !sclk_s && !cs_s;

  adc_sp_tx #(.RES_W(RES_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_low_i   (!cs_s),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .done_i     (done),
    .eoc_i      (eoc_i),
    .res_i      (res_i),
    .launch_o   (launch),
    .active_o   (active),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .rdy_o      (rdy_o)
  );

  adc_sp_rx #(.RES_W(RES_W), .SHORT_W(SHORT_W), .ADDR_W(ADDR_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .launch_i   (launch),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .sdi_i      (sdi_s),
    .lock_i     (lock_s),
    .done_o     (done),
    .addr_o     (mux_addr_o),
    .short_o    (short_word_o),
    .start_o    (conv_start_o)
  );

  always_comb begin
    abort_d = cs_fall && busy_q;
    busy_d  = busy_q;
    stale_d = stale_q;
    if (conv_start_o)          busy_d = 1'b1;
    else if (eoc_i || abort_d) busy_d = 1'b0;
    if (abort_d)    stale_d = 1'b1;
    else if (eoc_i) stale_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      abort_q <= abort_d;
      stale_q <= stale_d;
    end
  end

  assign conv_abort_o = abort_q;
  assign res_stale_o  = stale_q;

  p_abort_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> res_stale_o);
  p_abort_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |=> !conv_abort_o);
endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, rdonly = 1'b1, eoc = 1'b0;
  logic [12:0] res = '0;
  logic        sdo, sdo_oe, rdy, short_w, cstart, cabort, stale;
  logic [2:0]  addr;

  int n_chk = 0, n_fail = 0, n_start = 0, n_abort = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .rdonly_i(rdonly), .res_i(res), .eoc_i(eoc), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .rdy_o(rdy), .mux_addr_o(addr), .short_word_o(short_w),
    .conv_start_o(cstart), .conv_abort_o(cabort), .res_stale_o(stale)
  );

  always @(posedge clk) begin
    if (cstart) n_start++;
    if (cabort) n_abort++;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eoc_pulse(logic [12:0] v);
    res = v; eoc = 1'b1; tick(1); eoc = 1'b0; tick(3);
  endtask

  task automatic clock_bits(input logic [12:0] din, input int nclk,
                            inout logic [12:0] got, output bit rdy_pen);
    rdy_pen = 1'b0;
    for (int k = 0; k < nclk; k++) begin
      sdi = din[12-k];
      tick(H); sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
      if (k + 1 < nclk) got[12-(k+1)] = sdo;
      if (k + 2 == nclk) rdy_pen = rdy;
    end
  endtask

  task automatic frame(input logic [12:0] din, input int nclk, input bit lock,
                       output logic [12:0] got, output bit rdy_mid,
                       output bit rdy_pen, output bit rdy_end, output bit oe_mid);
    rdonly = lock; cs_n = 1'b0; tick(8);
    got = '0; got[12] = sdo; rdy_mid = rdy; oe_mid = sdo_oe;
    clock_bits(din, nclk, got, rdy_pen);
    rdy_end = rdy;
    cs_n = 1'b1; tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] got, v;
    bit rm, rp, re, oe;
    int s0, a0;
    tick(5); rst_n = 1'b1; tick(4);
    // R1 reset state
    check(sdo_oe == 0, "R1", "oe", sdo_oe, 0);
    check(rdy == 1, "R1", "rdy", rdy, 1);
    check(cstart == 0 && cabort == 0, "R1", "pulses", cstart | cabort, 0);
    check(addr == 0 && short_w == 0, "R1", "cfg", {addr, short_w}, 0);
    check(sdo == 0, "R2", "sdo idle", sdo, 0);

    // R3 R4 R8 R12: read-only sweep of results, all-ones command ignored
    for (int i = 0; i < 52; i++) begin
      v = (i == 0) ? 13'h1000 : (i == 1) ? 13'h0FFF : (i == 2) ? 13'h1FFF :
          13'(i * 157 + 3001);
      eoc_pulse(v);
      frame(13'h1FFF, 13, 1'b1, got, rm, rp, re, oe);
      check(got == v, "R3", "word", got, v);
      check(rm == 0 && rp == 0 && re == 1, "R4", "rdy", {rm, rp, re}, 1);
      check(oe == 1, "R2", "oe low cs", oe, 1);
    end
    check(n_start == 0, "R8", "no start", n_start, 0);
    check(addr == 0 && short_w == 0, "R8", "cfg kept", {addr, short_w}, 0);

    // R5 R6: configuration frame
    frame({3'b101, 1'b0, 9'h1AA}, 13, 1'b0, got, rm, rp, re, oe);
    check(n_start == 1, "R6", "start", n_start, 1);
    check(addr == 5, "R5", "addr", addr, 5);
    check(short_w == 0, "R5", "len", short_w, 0);
    eoc_pulse(13'h0123);

    // R7: truncated frame
    frame({3'b010, 1'b1, 9'h0}, 5, 1'b0, got, rm, rp, re, oe);
    check(n_start == 1, "R7", "no start", n_start, 1);
    check(addr == 5 && short_w == 0, "R7", "cfg kept", {addr, short_w}, {3'd5, 1'b0});

    // R9: 9-bit words
    frame({3'b011, 1'b1, 9'h0}, 13, 1'b0, got, rm, rp, re, oe);
    check(n_start == 2 && addr == 3 && short_w == 1, "R9", "cfg short",
          {n_start[3:0], addr, short_w}, {4'd2, 3'd3, 1'b1});
    for (int i = 0; i < 6; i++) begin
      v = 13'(i * 1297 + 91);
      eoc_pulse(v);
      frame(13'h0, 9, 1'b1, got, rm, rp, re, oe);
      check(got[12:4] == v[12:4], "R9", "short word", got[12:4], v[12:4]);
      check(rp == 0 && re == 1, "R9", "rdy at 9", {rp, re}, 1);
    end
    frame({3'b011, 1'b0, 9'h0}, 9, 1'b0, got, rm, rp, re, oe);
    check(short_w == 0 && n_start == 3, "R9", "back to 13", short_w, 0);
    eoc_pulse(13'h0555);

    // R11: abort
    frame({3'b001, 1'b0, 9'h0}, 13, 1'b0, got, rm, rp, re, oe);
    a0 = n_abort;
    check(stale == 0, "R11", "stale before", stale, 0);
    frame(13'h0, 13, 1'b1, got, rm, rp, re, oe);
    check(n_abort == a0 + 1, "R11", "abort", n_abort, a0 + 1);
    check(stale == 1, "R11", "stale set", stale, 1);
    eoc_pulse(13'h0777);
    check(stale == 0, "R11", "stale clear", stale, 0);

    // R10: select held low continuously
    s0 = n_start;
    rdonly = 1'b0; cs_n = 1'b0; tick(8);
    got = '0;
    clock_bits({3'b110, 1'b0, 9'h0}, 13, got, rp);
    check(n_start == s0 + 1 && addr == 6, "R10", "start", addr, 6);
    check(rdy == 1, "R10", "rdy idle", rdy, 1);
    rdonly = 1'b1;
    v = 13'h1ACE;
    res = v; eoc = 1'b1; tick(1); eoc = 1'b0; tick(2);
    check(sdo == v[12], "R10", "msb", sdo, v[12]);
    check(rdy == 0, "R10", "rdy low", rdy, 0);
    got = '0; got[12] = sdo;
    clock_bits(13'h0, 13, got, rp);
    check(got == v, "R10", "word", got, v);
    check(rdy == 1 && n_abort == a0 + 1, "R10", "end", rdy, 1);
    cs_n = 1'b1; tick(8);
    check(sdo_oe == 0 && sdo == 0, "R2", "oe off", sdo_oe, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule